// File: doc/BRIEF.md
# Load Result Byte Extractor

This block turns a cache line picked by the tag match into the value a load returns. It takes a 64-byte line, the byte position of the access within that line, a size code and an extension mode. A decoder marks the bytes of the accessed element. Every other byte is gated to zero. A shifter then moves the element to the low end of a 256-bit result, and an extension stage applies zero fill, sign fill or replication.

The decoder, the shift amount and the extension choice depend only on the offset, the size and the mode. They can therefore settle while the tag compare is still running, and the line data then passes through gates, a log-depth shifter and a fill/replicate layer. Only naturally aligned accesses of 1 to 32 bytes are served. Any other request raises an error flag and returns zero. An output register can be switched in by parameter.

Top module: `ld_extract`

## Requirements
- R1: Size codes 0, 1, 2, 3, 4 and 5 select 1, 2, 4, 8, 16 and 32 bytes. With mode 0 (zero extend), result byte i equals line byte offset+i for every i below the access size. Line byte k sits at line bits 8k+7..8k.
- R2: In zero-extend mode, every result byte at or above the access size is zero.
- R3: In mode 1 (sign extend) with sizes of 1 to 8 bytes, result bits from the element width up to bit 63 equal the element's top bit, and bits 64 to 255 are zero.
- R4: In mode 1 with 16- or 32-byte sizes, the result is the same as in zero-extend mode.
- R5: In mode 2 (broadcast), every element-sized chunk of the 256-bit result equals the loaded element.
- R6: An offset that is not a multiple of the access size sets err_o and forces the result to zero.
- R7: Size codes 6 and 7, and mode code 3, set err_o and force the result to zero.
- R8: With OUT_REG set, data_o and err_o reflect the inputs presented before the previous rising clock edge and hold until the next edge. An active rst_ni clears both to zero.
- R9: Line bytes outside the accessed element have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 512 | Cache line from the selected way |
| off_i | input | 6 | Byte offset of the access in the line |
| size_i | input | 3 | Access size code |
| mode_i | input | 2 | Extension mode: 0 zero, 1 sign, 2 broadcast, 3 illegal |
| data_o | output | 256 | Load result |
| err_o | output | 1 | Misaligned or illegal request |

## Verification
The bench builds the block with its defaults: a 64-byte line, a 32-byte result, sign fill to 8 bytes, and the output register present. With these values the bench can sweep every size code against every offset and every mode in a few thousand cycles. That sweep reaches every aligned slot, every misaligned offset and both unused size codes. Because the register is in place, the bench can also see the one-cycle latency, the hold between edges and the reset value at the ports.

// File: rtl/ld_extract_pkg.sv
package ld_extract_pkg;
  typedef enum logic [1:0] {
    EXT_ZERO  = 2'd0,
    EXT_SIGN  = 2'd1,
    EXT_BCAST = 2'd2,
    EXT_BAD   = 2'd3
  } ext_mode_e;
endpackage

// File: rtl/ld_gate_dec.sv
module ld_gate_dec #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAX_CODE   = 5,
  parameter int unsigned SZ_W       = 3,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [OFF_W-1:0]      off_i,
  input  logic [SZ_W-1:0]       size_i,
  output logic [LINE_BYTES-1:0] en_o,
  output logic                  bad_o
);
  logic             size_ok;
  logic             aligned;
  logic [OFF_W-1:0] low_mask;
  logic [OFF_W-1:0] keep_mask;

  always_comb begin
    size_ok   = (int'(size_i) <= int'(MAX_CODE));
    low_mask  = size_ok ? OFF_W'((1 << size_i) - 1) : '0;
    keep_mask = ~low_mask;
    aligned   = (off_i & low_mask) == '0;
    bad_o     = !size_ok || !aligned;
  end

  // each byte gate compares only the offset bits above the access size
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_gate
    assign en_o[b] = !bad_o && ((OFF_W'(b) & keep_mask) == (off_i & keep_mask));
  end

  always_comb begin
    if (!$isunknown({off_i, size_i}) && !bad_o) begin
      AST_EN_COUNT: assert ($countones(en_o) == (1 << size_i)); // R1
    end
  end
endmodule

// File: rtl/ld_align.sv
module ld_align #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned RES_BYTES  = 32,
  parameter int unsigned SZ_W       = 3,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned RES_W     = RES_BYTES * 8
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              bad_i,
  output logic [RES_W-1:0]  res_o
);
  logic [OFF_W:0][LINE_W-1:0] stg;

  assign stg[0] = line_i;
  // log-depth right shift by the byte offset
  for (genvar i = 0; i < OFF_W; i++) begin : g_shift
    assign stg[i+1] = off_i[i] ? (stg[i] >> (8 * (2 ** i))) : stg[i];
  end
  assign res_o = stg[OFF_W][RES_W-1:0];

  always_comb begin
    if (!$isunknown({off_i, size_i, bad_i}) && !bad_i) begin
      AST_ALIGN_UPPER: assert (stg[OFF_W][LINE_W-1:RES_W] == '0); // R9
      AST_ALIGN_FILL: assert ((res_o >> (8 << size_i)) == '0); // R2
    end
  end
endmodule

// File: rtl/ld_extend.sv
module ld_extend import ld_extract_pkg::*; #(
  parameter int unsigned RES_BYTES  = 32,
  parameter int unsigned SEXT_BYTES = 8,
  parameter int unsigned SZ_W       = 3,
  localparam int unsigned RES_W     = RES_BYTES * 8,
  localparam int unsigned SEXT_W    = SEXT_BYTES * 8,
  localparam int unsigned IDX_W     = $clog2(RES_W)
) (
  input  logic [RES_W-1:0] raw_i,
  input  logic [SZ_W-1:0]  size_i,
  input  ext_mode_e        mode_i,
  input  logic             bad_i,
  output logic [RES_W-1:0] res_o
);
  logic [IDX_W:0]   wbits;
  logic [IDX_W-1:0] wmask;
  logic             sbit;

  always_comb begin
    wbits = (IDX_W+1)'(8) << size_i;
    wmask = IDX_W'(wbits - 1'b1);
    sbit  = raw_i[wmask];
  end

  always_comb begin
    res_o = '0;
    if (!bad_i) begin
      unique case (mode_i)
        EXT_ZERO: res_o = raw_i;
        EXT_SIGN: begin
          if (int'(wbits) <= int'(SEXT_W)) begin
            for (int b = 0; b < int'(SEXT_W); b++)
              res_o[b] = (b < int'(wbits)) ? raw_i[b] : sbit;
          end else begin
            res_o = raw_i;
          end
        end
        EXT_BCAST: begin
          for (int b = 0; b < int'(RES_W); b++)
            res_o[b] = raw_i[IDX_W'(b) & wmask];
        end
        default: res_o = '0;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({size_i, mode_i, bad_i}) && !bad_i) begin
      if (mode_i == EXT_SIGN && int'(wbits) <= int'(SEXT_W)) begin
        AST_SIGN_UPPER: assert (res_o[RES_W-1:SEXT_W] == '0); // R3
      end
      if (mode_i == EXT_BCAST && int'(wbits) <= int'(RES_W / 2)) begin
        AST_BCAST_HALF: assert (res_o[RES_W-1:RES_W/2] == res_o[RES_W/2-1:0]); // R5
      end
    end
  end
endmodule

// File: rtl/ld_extract.sv
module ld_extract import ld_extract_pkg::*; #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned RES_BYTES  = 32,
  parameter int unsigned SEXT_BYTES = 8,
  parameter bit          OUT_REG    = 1'b1,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned RES_W     = RES_BYTES * 8,
  localparam int unsigned MAX_CODE  = $clog2(RES_BYTES),
  localparam int unsigned SZ_W      = $clog2(MAX_CODE + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [1:0]        mode_i,
  output logic [RES_W-1:0]  data_o,
  output logic              err_o
);
  logic [LINE_BYTES-1:0] byte_en;
  logic                  bad_dec;
  logic [LINE_W-1:0]     gated;
  logic [RES_W-1:0]      aligned_d;
  logic [RES_W-1:0]      res_d;
  logic                  err_d;
  ext_mode_e             mode_e;

  assign mode_e = ext_mode_e'(mode_i);
  assign err_d  = bad_dec || (mode_e == EXT_BAD);

  ld_gate_dec #(
    .LINE_BYTES(LINE_BYTES), .MAX_CODE(MAX_CODE), .SZ_W(SZ_W)
  ) u_dec (
    .off_i(off_i), .size_i(size_i), .en_o(byte_en), .bad_o(bad_dec)
  );

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_mask
    assign gated[b*8 +: 8] = line_i[b*8 +: 8] & {8{byte_en[b]}};
  end

  ld_align #(
    .LINE_BYTES(LINE_BYTES), .RES_BYTES(RES_BYTES), .SZ_W(SZ_W)
  ) u_align (
    .line_i(gated), .off_i(off_i), .size_i(size_i), .bad_i(bad_dec), .res_o(aligned_d)
  );

  ld_extend #(
    .RES_BYTES(RES_BYTES), .SEXT_BYTES(SEXT_BYTES), .SZ_W(SZ_W)
  ) u_ext (
    .raw_i(aligned_d), .size_i(size_i), .mode_i(mode_e), .bad_i(err_d), .res_o(res_d)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o <= '0;
        err_o  <= 1'b0;
      end else begin
        data_o <= res_d;
        err_o  <= err_d;
      end
    end
  end else begin : g_comb
    assign data_o = res_d;
    assign err_o  = err_d;
  end

  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> data_o == '0); // R6
endmodule

// File: tb/ld_extract_test.sv
`timescale 1ns/1ps
module ld_extract_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [511:0] line_i = '0;
  logic [5:0]   off_i = '0;
  logic [2:0]   size_i = '0;
  logic [1:0]   mode_i = '0;
  logic [255:0] data_o;
  logic         err_o;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  ld_extract uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .off_i(off_i),
    .size_i(size_i), .mode_i(mode_i), .data_o(data_o), .err_o(err_o)
  );

  function automatic logic [256:0] ref_load(logic [511:0] ln, int off, int sz, int md);
    logic [255:0] e, r;
    int n;
    if (sz > 5 || md == 3) return {1'b1, 256'b0};
    n = 1 << sz;
    if (off % n != 0) return {1'b1, 256'b0};
    e = '0;
    for (int i = 0; i < n; i++) e[i*8 +: 8] = ln[(off+i)*8 +: 8];
    r = e;
    if (md == 1 && n <= 8)
      for (int b = n*8; b < 64; b++) r[b] = e[n*8-1];
    if (md == 2)
      for (int b = 0; b < 256; b++) r[b] = e[b % (n*8)];
    return {1'b0, r};
  endfunction

  function automatic logic [511:0] rnd_line();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom;
    return l;
  endfunction

  task automatic check(string req, logic [256:0] exp);
    n_chk++;
    if ({err_o, data_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: got err=%0b data=%h exp err=%0b data=%h",
               req, err_o, data_o, exp[256], exp[255:0]);
    end
  endtask

  task automatic drive(logic [511:0] ln, int off, int sz, int md);
    @(negedge clk_i);
    line_i = ln; off_i = 6'(off); size_i = 3'(sz); mode_i = 2'(md);
    @(negedge clk_i);
  endtask

  task automatic run_one(string req, logic [511:0] ln, int off, int sz, int md);
    drive(ln, off, sz, md);
    check(req, ref_load(ln, off, sz, md));
  endtask

  task automatic t_reset();
    line_i = '1; off_i = '0; size_i = 3'd3; mode_i = 2'd1;
    repeat (3) @(negedge clk_i);
    check("R8 reset", '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero();
    logic [511:0] ln = rnd_line();
    for (int sz = 0; sz <= 5; sz++)
      for (int off = 0; off < 64; off += (1 << sz))
        run_one(sz >= 4 ? "R1 R2 wide" : "R1 R2", ln, off, sz, 0);
  endtask

  task automatic t_sign();
    logic [511:0] lines [3];
    lines[0] = rnd_line(); lines[1] = '1; lines[2] = {64{8'h7f}};
    for (int k = 0; k < 3; k++)
      for (int sz = 0; sz <= 5; sz++)
        for (int off = 0; off < 64; off += (1 << sz))
          run_one(sz <= 3 ? "R3 sign fill" : "R4 sign wide", lines[k], off, sz, 1);
  endtask

  task automatic t_bcast();
    logic [511:0] ln = rnd_line();
    for (int sz = 0; sz <= 5; sz++)
      for (int off = 0; off < 64; off += (1 << sz))
        run_one("R5 broadcast", ln, off, sz, 2);
  endtask

  task automatic t_misalign();
    logic [511:0] ln = rnd_line();
    for (int sz = 1; sz <= 5; sz++)
      for (int off = 1; off < 64; off++)
        if (off % (1 << sz) != 0)
          for (int md = 0; md < 3; md++) run_one("R6 misaligned", ln, off, sz, md);
  endtask

  task automatic t_illegal();
    logic [511:0] ln = rnd_line();
    for (int sz = 6; sz <= 7; sz++)
      for (int md = 0; md < 4; md++) run_one("R7 size code", ln, 0, sz, md);
    for (int sz = 0; sz <= 5; sz++) run_one("R7 mode code", ln, 0, sz, 3);
  endtask

  task automatic t_latency();
    logic [511:0] la = rnd_line();
    logic [511:0] lb = rnd_line();
    run_one("R8 first", la, 8, 3, 1);
    @(negedge clk_i);
    line_i = lb; off_i = 6'd16; size_i = 3'd4; mode_i = 2'd2;
    #2;
    check("R8 hold before edge", ref_load(la, 8, 3, 1));
    @(negedge clk_i);
    check("R8 after edge", ref_load(lb, 16, 4, 2));
  endtask

  task automatic t_isolate();
    for (int sz = 0; sz <= 5; sz++)
      for (int off = 0; off < 64; off += (1 << sz) * 3) begin
        logic [511:0] ln = rnd_line();
        logic [511:0] alt = ~ln;
        for (int i = 0; i < (1 << sz); i++) alt[(off+i)*8 +: 8] = ln[(off+i)*8 +: 8];
        for (int md = 0; md < 3; md++) begin
          drive(alt, off, sz, md);
          check("R9 outside bytes", ref_load(ln, off, sz, md));
        end
      end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_sign();
    t_bcast();
    t_misalign();
    t_illegal();
    t_latency();
    t_isolate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule